// File: doc/BRIEF.md
# Pipeline Exception Flush Controller

This block steers the fetch address and squashes in-flight instructions in a five-stage in-order pipeline (IF, ID, EX, MEM, WB) when the EX-stage arithmetic unit reports an overflow. On an overflow, fetch jumps to a fixed handler address. The instruction in IF is turned into a nop in the IF/ID register. The ID-stage and EX-stage control bundles are cleared, so the overflowing instruction and everything younger than it become bubbles. The return address, which is the PC+4 carried with the faulting instruction, is captured in an exception PC register.

A taken branch resolved in ID uses the same fetch steering. It squashes only the IF stage, and the branch itself goes on to complete. The load-use stall from the hazard unit is merged into the ID squash. Every port is a plain per-cycle control or status pin with no stream traffic, so there is no valid/ready handshake and no back-pressure. The strobes and the zeroed bundles are combinational and apply in the same cycle as their causes. Only the exception PC is registered.

Top module: `exc_flush_ctrl`

## Requirements
- R1: When `ex_ovf` is 1, `next_pc` equals the handler vector (default 0x40000040) and `pc_sel[1]` is 1.
- R2: When `id_br_taken` is 1 and `ex_ovf` is 0, `next_pc` equals `id_br_target` and `pc_sel` is 2'b01.
- R3: When both `ex_ovf` and `id_br_taken` are 0, `next_pc` equals `if_pc + 4` and `pc_sel` is 2'b00.
- R4: When overflow and a taken branch occur in the same cycle, `pc_sel` is 2'b11 and `next_pc` is the handler vector.
- R5: `if_flush` is 1 exactly when `ex_ovf` or `id_br_taken` is 1.
- R6: `id_flush` is 1 exactly when `ex_ovf` or `hdu_stall` is 1. `id_ctrl_out` is all zero when `id_flush` is 1 and equals `id_ctrl_in` otherwise.
- R7: `ex_flush` equals `ex_ovf`, so a taken branch alone never asserts it. `ex_ctrl_out` is all zero when `ex_flush` is 1 and equals `ex_ctrl_in` otherwise. As a result, the register-write bit (bit 0) of the faulting instruction never reaches WB.
- R8: In any flushed stage, the memory-write bit (bit 1 of the control bundle) is 0, so a squashed store cannot write memory.
- R9: At a rising clock edge with `ex_ovf` 1, `epc` loads `ex_pc_plus4`; for example, a faulting instruction at 0x4C gives 0x50. At any other edge, `epc` holds its value.
- R10: A synchronous active-high `rst` clears `epc` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ex_ovf | input | 1 | Overflow reported by the EX-stage instruction |
| id_br_taken | input | 1 | Branch compare result in ID (taken) |
| id_br_target | input | 32 | Branch target address |
| hdu_stall | input | 1 | Load-use stall request from hazard detection |
| ex_pc_plus4 | input | 32 | PC+4 travelling with the EX instruction |
| if_pc | input | 32 | Current fetch PC |
| id_ctrl_in | input | 6 | Control bundle decoded in ID |
| ex_ctrl_in | input | 6 | Control bundle held in ID/EX |
| pc_sel | output | 2 | Fetch mux select {exception, branch} |
| next_pc | output | 32 | Next fetch address |
| if_flush | output | 1 | Make the IF/ID instruction a nop |
| id_flush | output | 1 | Squash the ID control bundle |
| ex_flush | output | 1 | Squash the EX control bundle |
| id_ctrl_out | output | 6 | ID control bundle after squash |
| ex_ctrl_out | output | 6 | EX control bundle after squash |
| epc | output | 32 | Saved return address |

## Verification
Every steering and squash output is due in the same cycle as its inputs. The bench drives the inputs on the falling edge and compares those outputs a few nanoseconds later, before the next rising edge. `epc` is due one rising edge after the overflow, so it is checked after the following falling edge against a bench model that is updated on that rising edge. The bench also passes `ex_ctrl_out` through two model pipeline registers. It checks that the register-write bit of a faulting instruction reads 0 when that instruction reaches WB, two edges after the overflow.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned XLEN        = 32;
  localparam int unsigned CTRL_W      = 6;
  localparam int unsigned CTRL_REGWR  = 0;
  localparam int unsigned CTRL_MEMWR  = 1;

  typedef enum logic [1:0] {
    SEL_SEQ  = 2'b00,
    SEL_BR   = 2'b01,
    SEL_EXC  = 2'b10,
    SEL_BOTH = 2'b11
  } pc_sel_e;
endpackage

// File: rtl/pc_steer.sv
module pc_steer #(
  parameter int unsigned AW = 32,
  parameter logic [AW-1:0] VEC = 32'h4000_0040
) (
  input  logic          exc,
  input  logic          br,
  input  logic [AW-1:0] br_target,
  input  logic [AW-1:0] cur_pc,
  output logic [1:0]    sel,
  output logic [AW-1:0] npc
);
  localparam logic [AW-1:0] STEP = AW'(4);

  assign sel = {exc, br};

  always_comb begin
    unique casez (sel)
      2'b1?:   npc = VEC;
      2'b01:   npc = br_target;
      default: npc = cur_pc + STEP;
    endcase
  end
endmodule

// File: rtl/flush_gen.sv
module flush_gen (
  input  logic exc,
  input  logic br,
  input  logic stall,
  output logic f_if,
  output logic f_id,
  output logic f_ex
);
  assign f_if = exc | br;
  assign f_id = exc | stall;
  assign f_ex = exc;
endmodule

// File: rtl/ctrl_squash.sv
module ctrl_squash #(
  parameter int unsigned W = 6,
  parameter int unsigned MEMWR_BIT = 1
) (
  input  logic         kill,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] masked;

  always_comb begin
    masked = din;
    masked[MEMWR_BIT] = din[MEMWR_BIT] & ~kill;
    dout = kill ? '0 : masked;
  end
endmodule

// File: rtl/epc_reg.sv
module epc_reg #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/exc_flush_ctrl.sv
module exc_flush_ctrl
  import exc_pkg::*;
#(
  parameter logic [XLEN-1:0] HANDLER_VEC = 32'h4000_0040
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ex_ovf,
  input  logic              id_br_taken,
  input  logic [XLEN-1:0]   id_br_target,
  input  logic              hdu_stall,
  input  logic [XLEN-1:0]   ex_pc_plus4,
  input  logic [XLEN-1:0]   if_pc,
  input  logic [CTRL_W-1:0] id_ctrl_in,
  input  logic [CTRL_W-1:0] ex_ctrl_in,
  output logic [1:0]        pc_sel,
  output logic [XLEN-1:0]   next_pc,
  output logic              if_flush,
  output logic              id_flush,
  output logic              ex_flush,
  output logic [CTRL_W-1:0] id_ctrl_out,
  output logic [CTRL_W-1:0] ex_ctrl_out,
  output logic [XLEN-1:0]   epc
);
  localparam int unsigned NSTG = 2;

  logic [NSTG-1:0]             stg_kill;
  logic [NSTG-1:0][CTRL_W-1:0] stg_in;
  logic [NSTG-1:0][CTRL_W-1:0] stg_out;

  pc_steer #(.AW(XLEN), .VEC(HANDLER_VEC)) u_steer (
    .exc       (ex_ovf),
    .br        (id_br_taken),
    .br_target (id_br_target),
    .cur_pc    (if_pc),
    .sel       (pc_sel),
    .npc       (next_pc)
  );

  flush_gen u_flush (
    .exc   (ex_ovf),
    .br    (id_br_taken),
    .stall (hdu_stall),
    .f_if  (if_flush),
    .f_id  (id_flush),
    .f_ex  (ex_flush)
  );

  assign stg_kill = {ex_flush, id_flush};
  assign stg_in   = {ex_ctrl_in, id_ctrl_in};

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    ctrl_squash #(.W(CTRL_W), .MEMWR_BIT(CTRL_MEMWR)) u_sq (
      .kill (stg_kill[s]),
      .din  (stg_in[s]),
      .dout (stg_out[s])
    );
  end

  assign id_ctrl_out = stg_out[0];
  assign ex_ctrl_out = stg_out[1];

  epc_reg #(.AW(XLEN)) u_epc (
    .clk  (clk),
    .rst  (rst),
    .load (ex_ovf),
    .d    (ex_pc_plus4),
    .q    (epc)
  );
endmodule

// File: rtl/exc_flush_chk.sv
module exc_flush_chk
  import exc_pkg::*;
#(
  parameter logic [XLEN-1:0] HANDLER_VEC = 32'h4000_0040
) (
  input logic              clk,
  input logic              rst,
  input logic              ex_ovf,
  input logic              id_br_taken,
  input logic              hdu_stall,
  input logic [XLEN-1:0]   ex_pc_plus4,
  input logic [XLEN-1:0]   next_pc,
  input logic              ex_flush,
  input logic [CTRL_W-1:0] ex_ctrl_out,
  input logic [CTRL_W-1:0] id_ctrl_out,
  input logic [XLEN-1:0]   epc
);
  assert_vec_on_ovf_R1: assert property (@(posedge clk) disable iff (rst)
    ex_ovf |-> next_pc == HANDLER_VEC);

  assert_br_keeps_ex_R7: assert property (@(posedge clk) disable iff (rst)
    (id_br_taken && !ex_ovf) |-> !ex_flush);

  assert_ex_bubble_R7: assert property (@(posedge clk) disable iff (rst)
    ex_ovf |-> ex_ctrl_out == '0);

  assert_no_store_R8: assert property (@(posedge clk) disable iff (rst)
    (ex_ovf || hdu_stall) |-> !id_ctrl_out[CTRL_MEMWR]);

  assert_epc_load_R9: assert property (@(posedge clk) disable iff (rst)
    ex_ovf |=> epc == $past(ex_pc_plus4));

  assert_epc_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !ex_ovf |=> $stable(epc));
endmodule

bind exc_flush_ctrl exc_flush_chk #(.HANDLER_VEC(HANDLER_VEC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ex_ovf      (ex_ovf),
  .id_br_taken (id_br_taken),
  .hdu_stall   (hdu_stall),
  .ex_pc_plus4 (ex_pc_plus4),
  .next_pc     (next_pc),
  .ex_flush    (ex_flush),
  .ex_ctrl_out (ex_ctrl_out),
  .id_ctrl_out (id_ctrl_out),
  .epc         (epc)
);

// File: tb/tb_exc_flush_ctrl.sv
`timescale 1ns/1ps
module tb_exc_flush_ctrl;
  localparam logic [31:0] VEC = 32'h4000_0040;

  logic        clk = 1'b0;
  logic        rst;
  logic        ex_ovf, id_br_taken, hdu_stall;
  logic [31:0] id_br_target, ex_pc_plus4, if_pc;
  logic [5:0]  id_ctrl_in, ex_ctrl_in;
  logic [1:0]  pc_sel;
  logic [31:0] next_pc, epc;
  logic        if_flush, id_flush, ex_flush;
  logic [5:0]  id_ctrl_out, ex_ctrl_out;

  int unsigned vecs = 0;
  int unsigned miss = 0;
  logic [31:0] m_epc;
  logic [5:0]  mem_ctrl, wb_ctrl;
  logic        tag_mem, tag_wb;

  always #10 clk = ~clk;

  exc_flush_ctrl dut (
    .clk(clk), .rst(rst), .ex_ovf(ex_ovf), .id_br_taken(id_br_taken),
    .id_br_target(id_br_target), .hdu_stall(hdu_stall),
    .ex_pc_plus4(ex_pc_plus4), .if_pc(if_pc), .id_ctrl_in(id_ctrl_in),
    .ex_ctrl_in(ex_ctrl_in), .pc_sel(pc_sel), .next_pc(next_pc),
    .if_flush(if_flush), .id_flush(id_flush), .ex_flush(ex_flush),
    .id_ctrl_out(id_ctrl_out), .ex_ctrl_out(ex_ctrl_out), .epc(epc)
  );

  // model pipeline registers (EX->MEM->WB) and the EPC reference
  always @(posedge clk) begin
    mem_ctrl <= ex_ctrl_out;
    wb_ctrl  <= mem_ctrl;
    tag_mem  <= ex_ovf & ~rst;
    tag_wb   <= tag_mem;
    if (rst) m_epc <= '0;
    else if (ex_ovf) m_epc <= ex_pc_plus4;
  end

  function automatic logic [31:0] exp_npc(logic o, logic b, logic [31:0] t, logic [31:0] p);
    if (o) return VEC;
    if (b) return t;
    return p + 32'd4;
  endfunction

  function automatic logic [5:0] exp_ctrl(logic k, logic [5:0] c);
    return k ? 6'd0 : c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_comb();
    logic [1:0] es;
    es = {ex_ovf, id_br_taken};
    chk(next_pc == exp_npc(ex_ovf, id_br_taken, id_br_target, if_pc),
        ex_ovf ? (id_br_taken ? "R4" : "R1") : (id_br_taken ? "R2" : "R3"),
        next_pc, exp_npc(ex_ovf, id_br_taken, id_br_target, if_pc));
    chk(pc_sel == es, "R1/R2/R3 pc_sel", 32'(pc_sel), 32'(es));
    chk(if_flush == (ex_ovf | id_br_taken), "R5", 32'(if_flush), 32'(ex_ovf | id_br_taken));
    chk(id_flush == (ex_ovf | hdu_stall), "R6 flush", 32'(id_flush), 32'(ex_ovf | hdu_stall));
    chk(id_ctrl_out == exp_ctrl(ex_ovf | hdu_stall, id_ctrl_in), "R6 ctrl",
        32'(id_ctrl_out), 32'(exp_ctrl(ex_ovf | hdu_stall, id_ctrl_in)));
    chk(ex_flush == ex_ovf, "R7 flush", 32'(ex_flush), 32'(ex_ovf));
    chk(ex_ctrl_out == exp_ctrl(ex_ovf, ex_ctrl_in), "R7 ctrl",
        32'(ex_ctrl_out), 32'(exp_ctrl(ex_ovf, ex_ctrl_in)));
    if (ex_ovf)
      chk(!ex_ctrl_out[1] && !id_ctrl_out[1], "R8", 32'({ex_ctrl_out[1], id_ctrl_out[1]}), 32'd0);
  endtask

  task automatic drive(input logic o, b, s, input logic [31:0] t, p4, pc,
                       input logic [5:0] ci, ce);
    ex_ovf = o; id_br_taken = b; hdu_stall = s; id_br_target = t;
    ex_pc_plus4 = p4; if_pc = pc; id_ctrl_in = ci; ex_ctrl_in = ce;
  endtask

  // one cycle: drive at negedge, check comb, then after the edge check epc/WB
  task automatic step(input logic o, b, s, input logic [31:0] t, p4, pc,
                      input logic [5:0] ci, ce);
    @(negedge clk);
    drive(o, b, s, t, p4, pc, ci, ce);
    #3;
    check_comb();
    @(negedge clk);
    chk(epc == m_epc, "R9", epc, m_epc);
    if (tag_wb) chk(!wb_ctrl[0], "R7 wb", 32'(wb_ctrl[0]), 32'd0);
  endtask

  initial begin
    #2000000;
    miss++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1;
    drive(1'b0, 1'b0, 1'b0, '0, '0, '0, '0, '0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(epc == 32'd0, "R10", epc, 32'd0);
    // overflow during reset must not load
    drive(1'b1, 1'b0, 1'b0, '0, 32'h1234, '0, '0, '0);
    @(negedge clk);
    chk(epc == 32'd0, "R10 hold", epc, 32'd0);
    rst = 1'b0;
    drive(1'b0, 1'b0, 1'b0, '0, '0, '0, '0, '0);
    @(negedge clk);

    // directed: faulting add at 0x4C, fetch at 0x54
    step(1'b0, 1'b0, 1'b0, 32'h0, 32'h48, 32'h50, 6'h01, 6'h01);
    step(1'b1, 1'b0, 1'b0, 32'h0, 32'h50, 32'h54, 6'h3F, 6'h3F);
    chk(epc == 32'h50, "R9 0x50", epc, 32'h50);
    step(1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h4000_0040, 6'h03, 6'h03);
    // branch alone, stall alone, branch+exception, store in ID with stall
    step(1'b0, 1'b1, 1'b0, 32'h100, 32'h60, 32'h68, 6'h02, 6'h03);
    step(1'b0, 1'b0, 1'b1, 32'h100, 32'h64, 32'h6C, 6'h02, 6'h03);
    step(1'b1, 1'b1, 1'b1, 32'h200, 32'h70, 32'h78, 6'h3F, 6'h3F);
    // reset again clears epc
    @(negedge clk); rst = 1'b1; drive(1'b0, 1'b0, 1'b0, '0, '0, '0, '0, '0);
    @(negedge clk); rst = 1'b0;
    chk(epc == 32'd0 && m_epc == 32'd0, "R10 again", epc, 32'd0);

    for (int i = 0; i < 400; i++) begin
      step(($urandom % 5) == 0, ($urandom % 3) == 0, ($urandom % 4) == 0,
           $urandom, $urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FFFC,
           6'($urandom), 6'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule